// File: doc/BRIEF.md
# Seven-to-one pixel lane serializer

This block turns a stream of parallel RGB pixels into serial bit streams for a low-voltage differential display link. It runs in one fast clock domain at seven times the pixel rate. An internal seven-step bit counter opens the input once per pixel period. On that cycle the block latches one pixel: colour, horizontal sync, vertical sync and data-enable. Over the next seven fast cycles it shifts that pixel out, one bit per cycle, on each data lane. A forwarded clock lane repeats a fixed pattern once per pixel, aligned with the first serial bit.

A mode pin picks the colour depth. With 18-bit colour, three lanes carry six bits per channel plus the sync and enable bits. With 24-bit colour, a fourth lane also carries the two top bits of each channel.

The input follows valid/ready rules, but the block never applies back-pressure. `pix_ready` is a timing strobe, high for one cycle in every seven, and a pixel moves only when `pix_valid` and `pix_ready` are both high. If the source is not valid on the strobe, that pixel slot is sent as blanking: zero colour, with sync and enable low. A source should hold its pixel stable until it sees the strobe. Inputs seen between strobes have no effect.

Top module: `lvds_pixel_serializer`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, every data lane and the clock lane are low. The bit counter restarts, so `pix_ready` first rises six cycles after the first clock edge with `rst` low.
- R2: `pix_ready` is high for exactly one cycle in every seven fast cycles, outside reset.
- R3: Lane 0 sends, in the seven cycles after a capture and first bit first: R0, R1, R2, R3, R4, R5, G0.
- R4: Lane 1 sends, first bit first: G1, G2, G3, G4, G5, B0, B1.
- R5: Lane 2 sends, first bit first: B2, B3, B4, B5, horizontal sync, vertical sync, data-enable.
- R6: With `mode_24b` = 1 at capture, lane 3 sends, first bit first: R6, R7, G6, G7, B6, B7, then a spare bit that is always 0.
- R7: With `mode_24b` = 0 at capture, lane 3 stays low for the whole pixel, whatever the values of R6, R7, G6, G7, B6 and B7.
- R8: The clock lane sends 1,1,0,0,0,1,1 once per pixel. Its first bit is in the same cycle as the first data bit.
- R9: If `pix_valid` is 0 on the strobe cycle, lanes 0 to 3 send all zeros for that pixel. The clock lane still runs.
- R10: The first serial bit of a pixel appears in the fast cycle right after its capture edge. Input changes after that edge have no effect on the bits already being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit clock, seven times the pixel rate |
| rst | input | 1 | Synchronous active-high reset |
| mode_24b | input | 1 | 1 selects 24-bit colour on four lanes; 0 selects 18-bit colour on three lanes |
| pix_valid | input | 1 | Source holds a pixel |
| pix_ready | output | 1 | Capture strobe, one cycle in seven |
| pix_r | input | 8 | Red channel |
| pix_g | input | 8 | Green channel |
| pix_b | input | 8 | Blue channel |
| pix_hs | input | 1 | Horizontal sync |
| pix_vs | input | 1 | Vertical sync |
| pix_de | input | 1 | Data-enable |
| lane_data | output | 4 | Serial data lanes; bit n is lane n |
| lane_clk | output | 1 | Forwarded pixel-clock lane |

## Verification
The bench rebuilds every pixel from the seven bits collected on each lane and compares each field with what was driven.

- **24-bit mode:** a sweep of all 256 red values, with green and blue derived arithmetically so they differ. Every colour bit position ends up in both states next to differing neighbours, which exposes swapped or shifted positions within a lane. The low three bits of the index drive the sync and enable bits.
- **18-bit mode:** a 64-value run with the top colour bits forced high. This tells a correctly silenced fourth lane apart from one that leaks those bits.
- **Blanked slots** are sent in both modes.
- **Reset:** it is applied both from idle and in the middle of a pixel, to confirm the lanes clear and the strobe phase restarts.
- **Input changes after capture:** the inputs are inverted right after every capture, so any dependence on them after that edge shows up as a mismatch.

// File: rtl/lvds_ser_pkg.sv
package lvds_ser_pkg;
  localparam int COLOR_W       = 8;
  localparam int BITS_PER_LANE = 7;
  localparam int DATA_LANES    = 4;
  localparam int CNT_W         = $clog2(BITS_PER_LANE);

  // First-sent bit sits at the MSB of a lane word.
  localparam logic [BITS_PER_LANE-1:0] CLK_PATTERN = 7'b1100011;

  typedef struct packed {
    logic [COLOR_W-1:0] r;
    logic [COLOR_W-1:0] g;
    logic [COLOR_W-1:0] b;
    logic               hs;
    logic               vs;
    logic               de;
  } pixel_t;

  typedef logic [BITS_PER_LANE-1:0] lane_word_t;
endpackage

// File: rtl/lvds_bit_counter.sv
module lvds_bit_counter #(
  parameter int N = 7
) (
  input  logic clk,
  input  logic rst,
  output logic last
);
  localparam int CW = (N > 1) ? $clog2(N) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (last) cnt <= '0;
    else           cnt <= cnt + CW'(1);
  end

  assign last = (cnt == CW'(N - 1));

  // R2
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    last |=> !last);

  // R2
  strobe_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (!last && $past(last)) |-> (cnt == CW'(0)));
endmodule

// File: rtl/lvds_lane_packer.sv
module lvds_lane_packer
  import lvds_ser_pkg::*;
(
  input  pixel_t                          pix,
  input  logic                            valid,
  input  logic                            wide,
  output logic [DATA_LANES-1:0][BITS_PER_LANE-1:0] words
);
  pixel_t p;

  always_comb begin
    p = valid ? pix : '0;
    // leftmost element is sent first
    words[0] = {p.r[0], p.r[1], p.r[2], p.r[3], p.r[4], p.r[5], p.g[0]};
    words[1] = {p.g[1], p.g[2], p.g[3], p.g[4], p.g[5], p.b[0], p.b[1]};
    words[2] = {p.b[2], p.b[3], p.b[4], p.b[5], p.hs, p.vs, p.de};
    if (wide)
      words[3] = {p.r[6], p.r[7], p.g[6], p.g[7], p.b[6], p.b[7], 1'b0};
    else
      words[3] = '0;
  end
endmodule

// File: rtl/lvds_lane_shifter.sv
module lvds_lane_shifter #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic         sout
);
  logic [W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst)       sr <= '0;
    else if (load) sr <= din;
    else           sr <= {sr[W-2:0], 1'b0};
  end

  assign sout = sr[W-1];

  // R10
  first_bit_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (sout == $past(din[W-1])));
endmodule

// File: rtl/lvds_pixel_serializer.sv
module lvds_pixel_serializer
  import lvds_ser_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       mode_24b,
  input  logic       pix_valid,
  output logic       pix_ready,
  input  logic [7:0] pix_r,
  input  logic [7:0] pix_g,
  input  logic [7:0] pix_b,
  input  logic       pix_hs,
  input  logic       pix_vs,
  input  logic       pix_de,
  output logic [3:0] lane_data,
  output logic       lane_clk
);
  pixel_t                                   pix_in;
  logic [DATA_LANES-1:0][BITS_PER_LANE-1:0] words;
  logic                                     load;

  assign pix_in = '{r: pix_r, g: pix_g, b: pix_b, hs: pix_hs, vs: pix_vs, de: pix_de};

  lvds_bit_counter #(.N(BITS_PER_LANE)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .last (load)
  );

  assign pix_ready = load;

  lvds_lane_packer u_pack (
    .pix   (pix_in),
    .valid (pix_valid),
    .wide  (mode_24b),
    .words (words)
  );

  for (genvar i = 0; i < DATA_LANES; i++) begin : g_lane
    lvds_lane_shifter #(.W(BITS_PER_LANE)) u_sh (
      .clk  (clk),
      .rst  (rst),
      .load (load),
      .din  (words[i]),
      .sout (lane_data[i])
    );
  end

  lvds_lane_shifter #(.W(BITS_PER_LANE)) u_clk_sh (
    .clk  (clk),
    .rst  (rst),
    .load (load),
    .din  (CLK_PATTERN),
    .sout (lane_clk)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (lane_data == 4'b0 && !lane_clk && !pix_ready));

  // R7
  narrow_lane3_chk: assert property (@(posedge clk) disable iff (rst)
    (pix_ready && !mode_24b) |=> !lane_data[3]);

  // R8
  clk_lane_start_chk: assert property (@(posedge clk) disable iff (rst)
    pix_ready |=> lane_clk);

  // R9
  blank_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (pix_ready && !pix_valid) |=> (lane_data == 4'b0));
endmodule

// File: tb/lvds_pixel_serializer_tb.sv
module lvds_pixel_serializer_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_24b = 1'b0;
  logic       pix_valid = 1'b0;
  logic       pix_ready;
  logic [7:0] pix_r = '0, pix_g = '0, pix_b = '0;
  logic       pix_hs = 1'b0, pix_vs = 1'b0, pix_de = 1'b0;
  logic [3:0] lane_data;
  logic       lane_clk;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  lvds_pixel_serializer u_dut (
    .clk       (clk),
    .rst       (rst),
    .mode_24b  (mode_24b),
    .pix_valid (pix_valid),
    .pix_ready (pix_ready),
    .pix_r     (pix_r),
    .pix_g     (pix_g),
    .pix_b     (pix_b),
    .pix_hs    (pix_hs),
    .pix_vs    (pix_vs),
    .pix_de    (pix_de),
    .lane_data (lane_data),
    .lane_clk  (lane_clk)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Ends on a falling edge where pix_ready is high.
  task automatic reset_seq();
    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    check("R1 lanes low in reset", {27'b0, lane_clk, lane_data}, 32'h0);
    @(negedge clk) rst = 1'b0;
    check("R1 lanes low after reset", {27'b0, lane_clk, lane_data}, 32'h0);
    check("R1 ready low after reset", 32'(pix_ready), 32'h0);
    for (int n = 1; n <= 6; n++) begin
      @(negedge clk);
      check("R1 lanes idle", {27'b0, lane_clk, lane_data}, 32'h0);
      check("R1 R2 ready phase", 32'(pix_ready), 32'(n == 6));
    end
  endtask

  // Entered and left on a falling edge where pix_ready is high.
  task automatic send(bit v, bit m, logic [7:0] rr, logic [7:0] gg, logic [7:0] bb,
                      bit h, bit vv, bit d);
    logic [6:0] w0, w1, w2, w3, wc;
    logic [7:0] er, eg, eb;
    logic       eh, ev, ed;
    check("R2 strobe at entry", 32'(pix_ready), 32'h1);
    pix_valid = v; mode_24b = m;
    pix_r = rr; pix_g = gg; pix_b = bb;
    pix_hs = h; pix_vs = vv; pix_de = d;
    for (int k = 0; k < 7; k++) begin
      @(negedge clk);
      w0[k] = lane_data[0]; w1[k] = lane_data[1];
      w2[k] = lane_data[2]; w3[k] = lane_data[3];
      wc[k] = lane_clk;
      if (k == 0) begin
        // R10: disturb the inputs after capture
        pix_valid = ~v; mode_24b = ~m;
        pix_r = ~rr; pix_g = ~gg; pix_b = ~bb;
        pix_hs = ~h; pix_vs = ~vv; pix_de = ~d;
      end
      if (k < 6) check("R2 strobe low mid-pixel", 32'(pix_ready), 32'h0);
      else       check("R2 strobe returns", 32'(pix_ready), 32'h1);
    end
    er = v ? rr : 8'h0; eg = v ? gg : 8'h0; eb = v ? bb : 8'h0;
    eh = v & h; ev = v & vv; ed = v & d;
    check("R3 R10 lane0 red low", 32'(w0[5:0]), 32'(er[5:0]));
    check("R3 lane0 green bit0", 32'(w0[6]), 32'(eg[0]));
    check("R4 lane1 green", 32'(w1[4:0]), 32'(eg[5:1]));
    check("R4 lane1 blue low", 32'({w1[6], w1[5]}), 32'(eb[1:0]));
    check("R5 lane2 blue", 32'(w2[3:0]), 32'(eb[5:2]));
    check("R5 lane2 syncs", 32'({w2[4], w2[5], w2[6]}), 32'({eh, ev, ed}));
    if (m)
      check("R6 lane3 top bits",
            32'(w3), 32'({1'b0, eb[7], eb[6], eg[7], eg[6], er[7], er[6]}));
    else
      check("R7 lane3 quiet", 32'(w3), 32'h0);
    check("R8 clock lane", 32'(wc), 32'h63);
    if (!v) check("R9 blank slot", 32'({w3, w2, w1, w0}), 32'h0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    reset_seq();
    for (int i = 0; i < 256; i++) begin
      logic [7:0] iv;
      iv = 8'(i);
      send(1'b1, 1'b1, iv, 8'(i * 37 + 11), iv ^ 8'hA5, iv[0], iv[1], iv[2]);
    end
    for (int i = 0; i < 64; i++) begin
      logic [7:0] iv;
      iv = 8'(i);
      send(1'b1, 1'b0, 8'hC0 | iv, 8'hC0 | 8'(i * 3), ~iv, iv[2], iv[0], iv[1]);
    end
    send(1'b0, 1'b1, 8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b1);
    send(1'b0, 1'b0, 8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b1);
    send(1'b1, 1'b1, 8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b1);
    // mid-pixel reset
    pix_valid = 1'b1; mode_24b = 1'b1;
    pix_r = 8'hFF; pix_g = 8'hFF; pix_b = 8'hFF;
    @(negedge clk);
    @(negedge clk);
    reset_seq();
    send(1'b1, 1'b1, 8'h5A, 8'hC3, 8'h3C, 1'b0, 1'b1, 1'b0);
    send(1'b1, 1'b0, 8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b0, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule